// File: doc/BRIEF.md
# Ordered Completion Record Writer

This block writes a completion record into host memory so that a reader polling a flag byte can trust the payload next to it. A request carries a byte address, which is rounded down to the start of a 64-byte line, and a 256-bit payload made of four 64-bit fields. The block splits the record into 32-bit updates on a memory write port that uses a valid/ready handshake. The payload goes out first, in rising word order. A final single-byte update then sets the flag to 1. One ordered burst therefore replaces a pair of separate writes. The flag comes last because it has the highest address.

The slot layout puts field `f` at byte offset `8*f` and the flag byte at offset 32. A reader may see half of a 64-bit field updated before the other half. It can never see the flag set before any payload word. An optional two-phase mode pauses after the last payload word until an acknowledge arrives, and only then releases the flag. A relaxed-ordering bit is captured with the request and shown with every update of that record.

Top module: `cmp_writer`

## Requirements
- R1: Payload word `i` (0..7) of a record is `req_data[32*i +: 32]`. It goes to word address `line*16 + i`, where `line` is `req_base[31:6]`. The low half of each 64-bit field is therefore written before its high half.
- R2: A record is exactly nine handshaken updates, each one word address higher than the one before. Eight carry `mem_be = 4'b1111`. The ninth and last carries `mem_be = 4'b0001` and `mem_data = 32'h00000001` at word offset 8 (byte offset 32). After that update, all eight payload words of the slot are in memory.
- R3: Bits [5:0] of `req_base` have no effect on any update address.
- R4: A request with `req_valid` high is taken only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle after the flag update is handshaken. A request raised while `busy` is high changes no update.
- R5: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_data` and `mem_be` hold their values. The same update is offered until it is taken.
- R6: `mem_relaxed` equals the `req_relaxed` value captured at acceptance on every update of that record.
- R7: With `req_two_phase` high at acceptance, the block stops after the eighth payload update. It then holds `ack_wait` high and `mem_valid` low until `ack_in` is high at a clock edge, and only then offers the flag update. `ack_in` has no effect at any other time.
- R8: A request held high through the flag handshake is accepted at the first edge where `busy` is low. Its record follows the previous one with no overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_base | input | 32 | Byte address of the slot (low 6 bits ignored) |
| req_data | input | 256 | Four 64-bit payload fields, field 0 in the low bits |
| req_relaxed | input | 1 | Relaxed-ordering attribute for this record |
| req_two_phase | input | 1 | Wait for acknowledge before the flag update |
| busy | output | 1 | Record in progress |
| ack_in | input | 1 | Releases the flag update in two-phase mode |
| ack_wait | output | 1 | Payload done, waiting for acknowledge |
| mem_valid | output | 1 | Update offered |
| mem_ready | input | 1 | Update taken |
| mem_addr | output | 30 | Word address of the update |
| mem_data | output | 32 | Update data |
| mem_be | output | 4 | Byte enables |
| mem_relaxed | output | 1 | Relaxed-ordering attribute of the update |

## Verification
The flag update of one record and the acceptance of the next request can fall in neighbouring edges. A request that arrives while the flag update is still in flight must also be refused. The bench raises a second request during a record and keeps it high through the flag handshake. It then checks that none of the second payload appears inside the first record and that the second record begins right after `busy` falls. A stalled `mem_ready` can also coincide with the final payload word in two-phase mode. The stall patterns are swept across all four mode combinations to provoke this, and every logged update order is compared against the addresses computed in the bench.

// File: rtl/cmp_writer.sv
module cmp_writer #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int FIELDS     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_base,
  input  logic [FIELDS*64-1:0]  req_data,
  input  logic                  req_relaxed,
  input  logic                  req_two_phase,
  output logic                  busy,
  input  logic                  ack_in,
  output logic                  ack_wait,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [ADDR_W-3:0]     mem_addr,
  output logic [31:0]           mem_data,
  output logic [3:0]            mem_be,
  output logic                  mem_relaxed
);
  localparam int DWORDS   = FIELDS * 2;
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int OFF_W    = LINE_LSB - 2;
  localparam int LINE_W   = ADDR_W - LINE_LSB;
  localparam int IDX_W    = $clog2(DWORDS + 1);
  localparam int SEL_W    = $clog2(DWORDS);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_HOLD} st_t;

  st_t                  st;
  logic [IDX_W-1:0]     idx;
  logic [LINE_W-1:0]    line_q;
  logic [FIELDS*64-1:0] data_q;
  logic                 relax_q, two_q;
  logic [SEL_W-1:0]     sel;
  logic                 unused_base_lsb;

  wire fire      = mem_valid && mem_ready;
  wire flag_beat = idx == IDX_W'(DWORDS);
  wire last_data = idx == IDX_W'(DWORDS - 1);

  assign unused_base_lsb = ^req_base[LINE_LSB-1:0];
  assign sel         = idx[SEL_W-1:0];
  assign busy        = st != S_IDLE;
  assign ack_wait    = st == S_HOLD;
  assign mem_valid   = st == S_SEND;
  assign mem_addr    = {line_q, OFF_W'(idx)};
  assign mem_be      = flag_beat ? 4'b0001 : 4'b1111;
  assign mem_data    = flag_beat ? 32'h0000_0001 : data_q[int'(sel)*32 +: 32];
  assign mem_relaxed = relax_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      line_q  <= '0;
      data_q  <= '0;
      relax_q <= 1'b0;
      two_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          line_q  <= req_base[ADDR_W-1:LINE_LSB];
          data_q  <= req_data;
          relax_q <= req_relaxed;
          two_q   <= req_two_phase;
          idx     <= '0;
          st      <= S_SEND;
        end
        S_SEND: if (fire) begin
          if (flag_beat) st <= S_IDLE;
          else begin
            idx <= idx + 1'b1;
            if (last_data && two_q) st <= S_HOLD;
          end
        end
        S_HOLD: if (ack_in) st <= S_SEND;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmp_writer_chk.sv
module cmp_writer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              ack_wait,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [31:0]       mem_data,
  input logic [3:0]        mem_be,
  input logic              mem_relaxed
);
  logic              in_rec;
  logic [ADDR_W-3:0] prev_addr;
  logic              prev_relax;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_rec     <= 1'b0;
      prev_addr  <= '0;
      prev_relax <= 1'b0;
    end else if (mem_valid && mem_ready) begin
      in_rec     <= mem_be != 4'b0001;
      prev_addr  <= mem_addr;
      prev_relax <= mem_relaxed;
    end
  end

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be));
  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && in_rec |-> mem_addr == prev_addr + 1'b1);
  a_r2_flag_last: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_be == 4'b0001 |=> !busy);
  a_r2_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be == 4'b1111 || (mem_be == 4'b0001 && mem_data == 32'h1)));
  a_r4_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);
  a_r6_relaxed_steady: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && in_rec |-> mem_relaxed == prev_relax);
  a_r7_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wait |-> !mem_valid && busy);
endmodule

bind cmp_writer cmp_writer_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/cmp_writer_tb_top.sv
module cmp_writer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_base = '0;
  logic [255:0] req_data = '0;
  logic         req_relaxed = 1'b0, req_two_phase = 1'b0, ack_in = 1'b0, mem_ready = 1'b0;
  logic         busy, ack_wait, mem_valid, mem_relaxed;
  logic [29:0]  mem_addr;
  logic [31:0]  mem_data;
  logic [3:0]   mem_be;

  int errs = 0, checks = 0, tot = 0, stall = 0;
  logic [29:0] log_addr [1024];
  logic [31:0] log_data [1024];
  logic [3:0]  log_be   [1024];
  logic        log_rel  [1024];
  logic [31:0] mem [64];
  logic [7:0]  lfsr = 8'h5a;
  int          cyc = 0;
  logic        have_prev = 1'b0;
  logic [29:0] prev_a;
  logic [3:0]  prev_be;

  always #4 clk = ~clk;

  cmp_writer dut_i (.*);

  task automatic chk(input bit ok, input string req, input string msg, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, msg, act, exp);
    end
  endtask

  function automatic logic [255:0] mkdata(input int r);
    logic [255:0] d;
    for (int i = 0; i < 8; i++) d[32*i +: 32] = 32'hA500_0000 ^ (32'(r) << 8) ^ 32'(i * 17 + 3);
    return d;
  endfunction

  always begin
    @(posedge clk); #1;
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (stall)
      0: mem_ready = 1'b1;
      1: mem_ready = cyc[0];
      2: mem_ready = (cyc % 3) == 0;
      default: mem_ready = lfsr[0];
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (have_prev && prev_be != 4'b0001)
        chk(mem_addr == prev_a + 1, "R2", "ascending address", 64'(mem_addr), 64'(prev_a + 1));
      log_addr[tot] = mem_addr; log_data[tot] = mem_data;
      log_be[tot] = mem_be; log_rel[tot] = mem_relaxed;
      tot++;
      if (mem_be == 4'b1111) mem[mem_addr[5:0]] = mem_data;
      else if (mem_be == 4'b0001) begin
        mem[mem_addr[5:0]][7:0] = mem_data[7:0];
        for (int k = 0; k < 8; k++)
          chk(mem[6'(mem_addr[5:0] - 8 + k)] == log_data[tot - 9 + k], "R2", "payload present at flag",
              64'(mem[6'(mem_addr[5:0] - 8 + k)]), 64'(log_data[tot - 9 + k]));
      end
      have_prev = 1'b1; prev_a = mem_addr; prev_be = mem_be;
    end
  end

  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); n++; end while (busy && n < 400);
    chk(!busy, "R4", "record completes", 64'(busy), 64'd0);
  endtask

  task automatic check_rec(input int st, input logic [31:0] base, input logic [255:0] d, input logic rel, input string tag);
    logic [29:0] wb;
    wb = {base[31:6], 4'd0};
    for (int i = 0; i < 9; i++) begin
      logic [29:0] ea; logic [31:0] ed; logic [3:0] eb;
      ea = wb + 30'(i);
      ed = (i < 8) ? d[32*i +: 32] : 32'h1;
      eb = (i < 8) ? 4'b1111 : 4'b0001;
      chk(log_addr[st+i] == ea, "R1/R3", {tag, " addr"}, 64'(log_addr[st+i]), 64'(ea));
      chk(log_data[st+i] == ed && log_be[st+i] == eb, "R1/R2", {tag, " data/be"},
          {28'd0, log_be[st+i], log_data[st+i]}, {28'd0, eb, ed});
      chk(log_rel[st+i] == rel, "R6", {tag, " relaxed"}, 64'(log_rel[st+i]), 64'(rel));
    end
  endtask

  task automatic send_req(input logic [31:0] base, input logic [255:0] d, input logic rel, input logic tp);
    @(posedge clk); #1;
    req_valid = 1'b1; req_base = base; req_data = d; req_relaxed = rel; req_two_phase = tp;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic run_rec(input int r, input int st_mode, input logic rel, input logic tp);
    logic [31:0] base; logic [255:0] d; int st0, n;
    base = {8'(r * 37), 16'h1234, 2'(r), 6'(r * 11)};
    d = mkdata(r);
    stall = st_mode;
    mem[{2'(r), 4'd8}] = 32'h0;
    st0 = tot;
    send_req(base, d, rel, tp);
    @(negedge clk);
    chk(busy, "R4", "busy after accept", 64'(busy), 64'd1);
    @(posedge clk); #1;
    req_valid = 1'b1; req_data = ~d; req_base = 32'hFFFF_FFC0; req_relaxed = ~rel;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (tp) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!ack_wait && n < 400);
      chk(ack_wait && tot - st0 == 8, "R7", "paused after payload", 64'(tot - st0), 64'd8);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!mem_valid && ack_wait, "R7", "no flag before ack", 64'(mem_valid), 64'd0);
      end
      @(posedge clk); #1 ack_in = 1'b1;
      @(posedge clk); #1 ack_in = 1'b0;
    end
    wait_idle();
    chk(tot - st0 == 9, "R2", "nine updates", 64'(tot - st0), 64'd9);
    check_rec(st0, base, d, rel, "sweep");
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "ALL", "watchdog expired", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int st0, r;
    logic [255:0] da, db;
    logic [31:0] ba, bb;
    for (int k = 0; k < 64; k++) mem[k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_valid && !ack_wait, "R4", "reset state", {busy, mem_valid, ack_wait}, 64'd0);

    @(posedge clk); #1 ack_in = 1'b1;
    @(posedge clk); #1 ack_in = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_valid && tot == 0, "R7", "ack while idle ignored", 64'(tot), 64'd0);

    r = 0;
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int b = 0; b < 2; b++) begin
          run_rec(r, s, m[0], m[1]);
          r++;
        end

    stall = 0;
    ba = 32'h0000_0140; bb = 32'h0000_00BF;
    da = mkdata(90); db = mkdata(91);
    st0 = tot;
    send_req(ba, da, 1'b0, 1'b0);
    @(posedge clk); #1;
    req_valid = 1'b1; req_base = bb; req_data = db; req_relaxed = 1'b1; req_two_phase = 1'b0;
    do @(negedge clk); while (busy);
    chk(tot - st0 == 9, "R8", "first record whole before second", 64'(tot - st0), 64'd9);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk(busy, "R8", "held request accepted when idle", 64'(busy), 64'd1);
    wait_idle();
    check_rec(st0, ba, da, 1'b0, "R8 first");
    check_rec(st0 + 9, bb, db, 1'b1, "R8 second");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule